// File: doc/BRIEF.md
# DMA Global Control and Interrupt Registers

This block is the shared register bank of a twelve-channel DMA engine. Software reaches it through a simple 32-bit register port with separate write and read strobes. Through that port it sets each channel's transfer mode and direction, and it chooses which channels may raise the interrupt. It also reads and acknowledges per-channel completion and error events. The bank sends each channel's mode and direction to that channel's engine. In return it takes from each engine a live 2-bit activity state and single-cycle completion and error pulses.

Channels 0 to 7 and channels 8 to 11 sit in separate words, so the field positions differ between the two groups. The event words hold three kinds of field side by side: sticky pending bits, sticky error bits (both cleared by writing 1) and read-only live state fields. One interrupt line is driven by a two-state machine. In state `IRQ_QUIET` the line is low; the transition to `IRQ_RAISED` is taken when any enabled channel has a pending event. In `IRQ_RAISED` the line is high, and the machine returns to `IRQ_QUIET` once no enabled channel is pending. Because the state is registered, the line follows the pending bits one cycle late.

Top module: `dmac_global_regs`

## Requirements
- R1: After reset every mode, direction, interrupt enable, pending and error bit is 0, `irq` is low and `rdata` is 0.
- R2: The low configuration word at offset 0x00 gives channel c (0 to 7) a nibble at bit 4c: bits [1:0] hold the mode and bit 2 holds the direction, and bit 3 reads 0. The high configuration word at 0x0C gives channels 8 to 11 the same nibble at bit 4(c-8), and its bits 31:16 read 0. `ch_mode[2c+1:2c]` and `ch_dir[c]` show the stored values, and a write to one word leaves the channels of the other word unchanged.
- R3: When a written nibble carries the mode value 3, that channel keeps its current mode. The direction bit is stored on every write to the word.
- R4: The enable word at 0x08 holds the enables of channels 0 to 7 in bits 7:0 and those of channels 8 to 11 in bits 19:16. All other bits read 0.
- R5: The low event word at 0x10 holds channel c's pending bit at bit c and its error bit at bit c+8. The high event word at 0x18 does the same for channel c using c-8. A `ch_done` pulse sets the pending bit. A `ch_err` pulse sets both the pending bit and the error bit.
- R6: Writing 1 to a pending or error bit of an event word clears that bit. Writing 0 leaves it unchanged.
- R7: An event that arrives in the same cycle as a write clearing its pending bit leaves the bit set.
- R8: Bits [17+2k:16+2k] of an event word show the live `ch_state` of the channel at position k of that word. Writes to these bits are ignored.
- R9: `irq` rises one clock after a pending bit with its enable set is stored. It falls one clock after no enabled pending bit remains. Pending bits whose enable is clear never raise it.
- R10: Offsets 0x04 and 0x14, and every other address not listed here, read as 0, and writes to them change no state.
- R11: A read returns the addressed word on `rdata` in the cycle after `rd_en`. `rdata` holds that value while `rd_en` stays low, even if the register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; `rdata` updates on the next edge |
| addr | input | ADDR_W | Byte offset of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ch_state | input | 2*NUM_CH | Live 2-bit activity state of each channel engine |
| ch_done | input | NUM_CH | One-cycle completion pulse per channel |
| ch_err | input | NUM_CH | One-cycle error pulse per channel |
| ch_mode | output | 2*NUM_CH | Stored mode of each channel |
| ch_dir | output | NUM_CH | Stored direction of each channel |
| irq | output | 1 | Combined interrupt line |

## Verification
The bench fills nibbles with every combination of mode and direction, including the mode value 3. A design that treated 3 as an ordinary mode would show it on `ch_mode`, and one that skipped the direction bit on a keep would leave `ch_dir` stale. It raises an event in the same cycle as the write that clears it, and it writes zero masks to the event words. Clear-priority logic would lose the new event, and a toggle or write-through implementation would drop bits that were never acknowledged. It also checks `irq` on both sides of its one-cycle lag, with the enable masked and unmasked. It checks that `rdata` holds after a read. A line driven straight from the pending bits, or a read port that tracks the register continuously, shows up at those sample points.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    localparam int DATA_W    = 32;
    localparam int BANK_CH   = 8;   // channels held by the low words
    localparam int NIB       = 4;   // configuration field width per channel
    localparam int ERR_OFS   = 8;   // error bit offset within an event word
    localparam int STATE_OFS = 16;  // first state field within an event word
    localparam int HI_EN_OFS = 16;  // first enable bit of the high group

    localparam logic [7:0] OFS_CFG_LO = 8'h00;
    localparam logic [7:0] OFS_SPARE0 = 8'h04;
    localparam logic [7:0] OFS_IRQ_EN = 8'h08;
    localparam logic [7:0] OFS_CFG_HI = 8'h0C;
    localparam logic [7:0] OFS_EVT_LO = 8'h10;
    localparam logic [7:0] OFS_SPARE1 = 8'h14;
    localparam logic [7:0] OFS_EVT_HI = 8'h18;

    localparam logic [1:0] MODE_KEEP = 2'b11;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/dmac_chan_cell.sv
module dmac_chan_cell
    import dmac_regs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [NIB-1:0] cfg_nib,
    input  logic           en_we,
    input  logic           en_val,
    input  logic           clr_we,
    input  logic           clr_pend,
    input  logic           clr_err,
    input  logic           done_i,
    input  logic           err_i,
    output logic [1:0]     mode_o,
    output logic           dir_o,
    output logic           en_o,
    output logic           pend_o,
    output logic           err_o
);

    logic pend_drop;
    logic err_drop;

    assign pend_drop = clr_we && clr_pend;
    assign err_drop  = clr_we && clr_err;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= 2'b00;
            dir_o  <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_nib[1:0] != MODE_KEEP) begin
                mode_o <= cfg_nib[1:0];
            end
            dir_o <= cfg_nib[2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= 1'b0;
        end else if (en_we) begin
            en_o <= en_val;
        end
    end

    // A new event is ORed in after the clear, so it survives a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            err_o  <= 1'b0;
        end else begin
            pend_o <= (pend_o && !pend_drop) || done_i || err_i;
            err_o  <= (err_o && !err_drop) || err_i;
        end
    end

endmodule

// File: rtl/dmac_irq_fsm.sv
module dmac_irq_fsm
    import dmac_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (req_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!req_i) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/dmac_global_regs.sv
module dmac_global_regs
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [2*NUM_CH-1:0] ch_state,
    input  logic [NUM_CH-1:0]   ch_done,
    input  logic [NUM_CH-1:0]   ch_err,
    output logic [2*NUM_CH-1:0] ch_mode,
    output logic [NUM_CH-1:0]   ch_dir,
    output logic                irq
);

    logic wr_cfg_lo, wr_cfg_hi, wr_irq_en, wr_evt_lo, wr_evt_hi;

    assign wr_cfg_lo = wr_en && (addr == ADDR_W'(OFS_CFG_LO));
    assign wr_cfg_hi = wr_en && (addr == ADDR_W'(OFS_CFG_HI));
    assign wr_irq_en = wr_en && (addr == ADDR_W'(OFS_IRQ_EN));
    assign wr_evt_lo = wr_en && (addr == ADDR_W'(OFS_EVT_LO));
    assign wr_evt_hi = wr_en && (addr == ADDR_W'(OFS_EVT_HI));

    logic [NUM_CH-1:0] en_v;
    logic [NUM_CH-1:0] pend_v;
    logic [NUM_CH-1:0] err_v;

    logic [DATA_W-1:0] cfg_part [NUM_CH];
    logic [DATA_W-1:0] evt_part [NUM_CH];
    logic [DATA_W-1:0] en_part  [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam bit IS_HI  = (c >= BANK_CH);
        localparam int K      = IS_HI ? c - BANK_CH : c;
        localparam int EN_POS = IS_HI ? HI_EN_OFS + K : K;

        dmac_chan_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (IS_HI ? wr_cfg_hi : wr_cfg_lo),
            .cfg_nib  (wdata[NIB*K +: NIB]),
            .en_we    (wr_irq_en),
            .en_val   (wdata[EN_POS]),
            .clr_we   (IS_HI ? wr_evt_hi : wr_evt_lo),
            .clr_pend (wdata[K]),
            .clr_err  (wdata[K + ERR_OFS]),
            .done_i   (ch_done[c]),
            .err_i    (ch_err[c]),
            .mode_o   (ch_mode[2*c +: 2]),
            .dir_o    (ch_dir[c]),
            .en_o     (en_v[c]),
            .pend_o   (pend_v[c]),
            .err_o    (err_v[c])
        );

        assign cfg_part[c] = DATA_W'({1'b0, ch_dir[c], ch_mode[2*c +: 2]}) << (NIB*K);
        assign en_part[c]  = DATA_W'(en_v[c]) << EN_POS;
        assign evt_part[c] = (DATA_W'(pend_v[c]) << K)
                           | (DATA_W'(err_v[c]) << (K + ERR_OFS))
                           | (DATA_W'(ch_state[2*c +: 2]) << (STATE_OFS + 2*K));
    end

    logic [DATA_W-1:0] cfg_lo_w, cfg_hi_w, en_w, evt_lo_w, evt_hi_w;

    always_comb begin
        cfg_lo_w = '0;
        cfg_hi_w = '0;
        en_w     = '0;
        evt_lo_w = '0;
        evt_hi_w = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            en_w = en_w | en_part[c];
            if (c < BANK_CH) begin
                cfg_lo_w = cfg_lo_w | cfg_part[c];
                evt_lo_w = evt_lo_w | evt_part[c];
            end else begin
                cfg_hi_w = cfg_hi_w | cfg_part[c];
                evt_hi_w = evt_hi_w | evt_part[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                ADDR_W'(OFS_CFG_LO): rdata <= cfg_lo_w;
                ADDR_W'(OFS_IRQ_EN): rdata <= en_w;
                ADDR_W'(OFS_CFG_HI): rdata <= cfg_hi_w;
                ADDR_W'(OFS_EVT_LO): rdata <= evt_lo_w;
                ADDR_W'(OFS_EVT_HI): rdata <= evt_hi_w;
                default:             rdata <= '0;
            endcase
        end
    end

    dmac_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (|(pend_v & en_v)),
        .irq_o (irq)
    );

    logic unused_wdata;
    assign unused_wdata = ^wdata;

endmodule

// File: rtl/dmac_global_regs_chk.sv
module dmac_global_regs_chk
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 12,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_CH-1:0]   ch_done,
    input logic [NUM_CH-1:0]   ch_err,
    input logic [2*NUM_CH-1:0] ch_mode,
    input logic [NUM_CH-1:0]   ch_dir,
    input logic                irq,
    input logic [NUM_CH-1:0]   pend,
    input logic [NUM_CH-1:0]   en
);

    logic cfg_write, evt_write;
    assign cfg_write = wr_en && (addr == ADDR_W'(OFS_CFG_LO) || addr == ADDR_W'(OFS_CFG_HI));
    assign evt_write = wr_en && (addr == ADDR_W'(OFS_EVT_LO) || addr == ADDR_W'(OFS_EVT_HI));

    // R1: the line is low on the first edge out of reset
    a_r1_irq_quiet_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

    // R9: enabled pending event raises the line one edge later
    a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & en)) |=> irq);

    // R9: line drops one edge after no enabled pending bit remains
    a_r9_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & en)) |=> !irq);

    // R7: every pulsed channel is pending on the next edge, clear or not
    a_r7_event_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ch_done | ch_err)) |=> ((pend & $past(ch_done | ch_err)) == $past(ch_done | ch_err)));

    // R6: pending bits drop only through a write to an event word
    a_r6_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_write |=> ((pend & $past(pend)) == $past(pend)));

    // R2: configuration outputs hold without a configuration write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_write |=> ($stable(ch_mode) && $stable(ch_dir)));

endmodule

bind dmac_global_regs dmac_global_regs_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .ch_done (ch_done),
    .ch_err  (ch_err),
    .ch_mode (ch_mode),
    .ch_dir  (ch_dir),
    .irq     (irq),
    .pend    (pend_v),
    .en      (en_v)
);

// File: tb/test_dmac_global_regs.sv
`timescale 1ns/1ps
module test_dmac_global_regs;

    localparam int NCH = 12;
    localparam int AW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [2*NCH-1:0] ch_state = '0;
    logic [NCH-1:0]  ch_done = '0;
    logic [NCH-1:0]  ch_err = '0;
    logic [2*NCH-1:0] ch_mode;
    logic [NCH-1:0]  ch_dir;
    logic            irq;

    always #2.5 clk = ~clk;

    dmac_global_regs #(.NUM_CH(NCH), .ADDR_W(AW)) i_dmac_global_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_state(ch_state), .ch_done(ch_done),
        .ch_err(ch_err), .ch_mode(ch_mode), .ch_dir(ch_dir), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;
    logic        done_flag = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
        ch_done = dn; ch_err = er;
        @(negedge clk);
        ch_done = '0; ch_err = '0;
    endtask

    function automatic logic [2*NCH-1:0] state_pattern();
        logic [2*NCH-1:0] p;
        for (int c = 0; c < NCH; c++) p[2*c +: 2] = 2'(c % 4);
        return p;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        ch_state = state_pattern();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ch_mode", 32'(ch_mode), 32'h0);
        chk("R1 ch_dir", 32'(ch_dir), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        rd(8'h00, 32'h0, "R1 cfg lo");
        rd(8'h08, 32'h0, "R1 enables");
        rd(8'h0C, 32'h0, "R1 cfg hi");
        rd(8'h10, 32'hE4E4_0000, "R1/R8 evt lo");
        rd(8'h18, 32'h00E4_0000, "R1/R8 evt hi");

        // R2/R3 low configuration word with every mode and direction
        wr(8'h00, 32'h7654_3210);
        chk("R3 ch_mode lo", 32'(ch_mode[15:0]), 32'h2424);
        chk("R2 ch_dir lo", 32'(ch_dir[7:0]), 32'hF0);
        rd(8'h00, 32'h4654_0210, "R2 cfg lo readback");
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R3 keep ch_dir", 32'(ch_dir[7:0]), 32'hFF);
        rd(8'h00, 32'h4654_4654, "R3 keep all modes");

        // R2/R3 high configuration word
        wr(8'h0C, 32'hFFFF_ABCD);
        chk("R2 ch_mode hi", 32'(ch_mode[23:16]), 32'h81);
        chk("R3 ch_dir hi", 32'(ch_dir[11:8]), 32'h3);
        rd(8'h0C, 32'h0000_2045, "R2 cfg hi readback");
        rd(8'h00, 32'h4654_4654, "R2 lo untouched by hi write");

        // R4 enables
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h000F_00FF, "R4 enable packing");
        wr(8'h08, 32'h0004_0008);
        rd(8'h08, 32'h0004_0008, "R4 enable ch3 ch10");

        // R10 spare and unmapped addresses
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R10 spare 0x04");
        rd(8'h14, 32'h0, "R10 spare 0x14");
        rd(8'h1C, 32'h0, "R10 unmapped 0x1C");
        rd(8'h20, 32'h0, "R10 unmapped 0x20");
        rd(8'h00, 32'h4654_4654, "R10 cfg lo unchanged");
        rd(8'h08, 32'h0004_0008, "R10 enables unchanged");

        // R8 state fields read-only and live
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'hE4E4_0000, "R8 state ignores write");
        ch_state = ~state_pattern();
        rd(8'h10, 32'h1B1B_0000, "R8 state live lo");
        rd(8'h18, 32'h001B_0000, "R8 state live hi");
        ch_state = '0;

        // R5/R9 masked event
        pulse(12'h020, 12'h000);
        chk("R9 masked no irq", 32'(irq), 32'h0);
        rd(8'h10, 32'h0000_0020, "R5 done ch5");
        chk("R9 masked still low", 32'(irq), 32'h0);

        // R5/R9 error on enabled channel 10
        pulse(12'h000, 12'h400);
        chk("R9 irq lags pending", 32'(irq), 32'h0);
        @(negedge clk);
        chk("R9 irq raised", 32'(irq), 32'h1);
        rd(8'h18, 32'h0000_0404, "R5 error ch10");

        // R6 write one to clear
        wr(8'h18, 32'h0000_0000);
        rd(8'h18, 32'h0000_0404, "R6 zero write no effect");
        chk("R9 irq held", 32'(irq), 32'h1);
        wr(8'h18, 32'h0000_0004);
        rd(8'h18, 32'h0000_0400, "R6 pending cleared error kept");
        chk("R9 irq dropped", 32'(irq), 32'h0);
        wr(8'h18, 32'h0000_0400);
        rd(8'h18, 32'h0000_0000, "R6 error cleared");

        // R7 event in the same cycle as its clear
        ch_done = 12'h008;
        wr_en = 1'b1; addr = 8'h10; wdata = 32'h0000_0028;
        @(negedge clk);
        ch_done = '0; wr_en = 1'b0; wdata = '0;
        rd(8'h10, 32'h0000_0008, "R7 event beats clear");
        chk("R9 irq from ch3", 32'(irq), 32'h1);
        wr(8'h10, 32'h0000_0008);
        @(negedge clk);
        chk("R9 irq off after clear", 32'(irq), 32'h0);

        // R5 done and error on different channels together
        pulse(12'h001, 12'h080);
        rd(8'h10, 32'h0000_8081, "R5 mixed events lo");

        // R1 reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 ch_mode after reset", 32'(ch_mode), 32'h0);
        rd(8'h10, 32'h0, "R1 evt lo after reset");
        rd(8'h00, 32'h0, "R1 cfg lo after reset");

        // R11 read data holds between reads
        rd(8'h08, 32'h0, "R11 enables zero");
        wr(8'h08, 32'h0000_00FF);
        chk("R11 rdata holds", rdata, 32'h0);
        rd(8'h08, 32'h0000_00FF, "R11 new read");
        @(negedge clk);

        done_flag = 1'b1;
        summary();
    end

endmodule